// File: doc/BRIEF.md
# SDRAM Bank State Protocol Checker

This block is a passive monitor that sits beside the command pins of a four-bank SDRAM. On every rising clock edge it samples the chip select, the three command strobes, the bank select and address bit 10. It keeps a state and a timer for each bank, and it uses that state to judge whether the command just issued is allowed. The block never drives the memory bus and keeps no data.

A command that breaks a rule produces a single-cycle error pulse on the clock edge after the command. The pulse carries a code for the rule that was broken and the number of the bank involved. An illegal command has no effect on the tracked bank state, so one mistake is reported once and does not cause later reports. Each timing minimum is a clock count set by a parameter: activate-to-column, precharge, row active, activate-to-activate, write recovery, refresh cycle and mode-register recovery. The burst length is also a parameter. The monitor is meant for a simulation bench or an on-chip protocol checker that watches a memory controller.

Top module: `sdram_bank_checker`

## Requirements
- R1: While reset is low, err_pulse is 0 and err_code is 0. A command sampled at edge k produces the result at edge k+1: err_pulse=1, err_code set to the rule code (1 to 11) and err_bank set to the bank. No-op and deselect never raise an error unless the rules below say so. Commands are decoded from {cs_n,ras_n,cas_n,we_n} as follows: 0000 mode set, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0110 burst stop, 0111 no-op, 1xxx deselect.
- R2: A mode set or refresh issued while any bank is not idle gives code 1. err_bank is the lowest-numbered bank that is not idle.
- R3: A read or write to an idle bank gives code 2.
- R4: An activate to a bank whose row is open (activating, active, or in a burst or write recovery without auto-precharge) gives code 3.
- R5: A read or write issued fewer than T_RCD clocks after the activate of that bank gives code 4.
- R6: An activate, read or write to a bank that is precharging gives code 5. The bank is idle again T_RP clocks after the precharge began.
- R7: While a bank is running a burst with auto-precharge (a10=1 on the read or write), up to the start of its internal precharge, any activate, read, write or precharge aimed at it gives code 6.
- R8: An activate issued fewer than T_RRD clocks after the last legal activate to any bank gives code 7.
- R9: Within T_MRD clocks of a legal mode set, any command other than no-op or deselect gives code 8. err_bank is the command's bank field.
- R10: Within T_RC clocks of a legal refresh, any command other than no-op or deselect gives code 9. err_bank is the command's bank field.
- R11: A precharge issued fewer than T_RAS clocks after the activate of that bank gives code 10.
- R12: A precharge to a bank in write recovery (the T_WR clocks after its write burst ends) gives code 11.
- R13: A command to one bank is judged only by that bank's own state. A precharge with a10=1 is judged against every bank, and the lowest-numbered bank that violates a rule is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset; all banks idle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Auto-precharge select on read/write; all-banks select on precharge |
| err_pulse | output | 1 | One-cycle flag for an illegal command |
| err_code | output | 4 | Code of the broken rule, 0 when no error |
| err_bank | output | BA_W | Bank the error concerns |

## Verification
The hardest states to reach are the chained timed states: a write with auto-precharge passes through its burst, then write recovery, then precharging, and a command must land in each phase. The stimulus counts clocks exactly from the write and places an activate, a read and a precharge on chosen cycles. The lowest-bank rule of an all-banks precharge is reached by opening two banks a few clocks apart, so that both are still inside their row-active minimum. Refresh and mode-set lockouts are probed with commands to banks that are otherwise idle, so that only the global window can flag them.

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker #(
  parameter int BA_W  = 2,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 6,
  parameter int T_RRD = 2,
  parameter int T_WR  = 2,
  parameter int T_RC  = 8,
  parameter int T_MRD = 2,
  parameter int BURST = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            err_pulse,
  output logic [3:0]      err_code,
  output logic [BA_W-1:0] err_bank
);
  localparam int NB = 1 << BA_W;
  localparam int M1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M2 = (T_RAS > T_RRD) ? T_RAS : T_RRD;
  localparam int M3 = (T_WR > T_RC) ? T_WR : T_RC;
  localparam int M4 = (T_MRD > BURST) ? T_MRD : BURST;
  localparam int M5 = (M1 > M2) ? M1 : M2;
  localparam int M6 = (M3 > M4) ? M3 : M4;
  localparam int TMAX = (M5 > M6) ? M5 : M6;
  localparam int CW = $clog2(TMAX + 1);

  localparam logic [3:0] E_NONE = 4'd0, E_BUSY = 4'd1, E_NOROW = 4'd2, E_OPEN = 4'd3,
                         E_RCD = 4'd4, E_PRE = 4'd5, E_AUTO = 4'd6, E_RRD = 4'd7,
                         E_MRD = 4'd8, E_RFC = 4'd9, E_RAS = 4'd10, E_WREC = 4'd11;

  typedef enum logic [3:0] {
    S_IDLE, S_ACTG, S_ACT, S_RD, S_WR, S_WREC, S_PRE, S_REF, S_MRS
  } st_t;

  logic c_nop, c_mrs, c_ref, c_pre, c_act, c_wr, c_rd, c_bst;
  assign c_nop = cs_n | (ras_n & cas_n & we_n);
  assign c_mrs = ~cs_n & ~ras_n & ~cas_n & ~we_n;
  assign c_ref = ~cs_n & ~ras_n & ~cas_n &  we_n;
  assign c_pre = ~cs_n & ~ras_n &  cas_n & ~we_n;
  assign c_act = ~cs_n & ~ras_n &  cas_n &  we_n;
  assign c_wr  = ~cs_n &  ras_n & ~cas_n & ~we_n;
  assign c_rd  = ~cs_n &  ras_n & ~cas_n &  we_n;
  assign c_bst = ~cs_n &  ras_n &  cas_n & ~we_n;

  st_t           st    [NB];
  logic [CW-1:0] cnt   [NB];
  logic          ap    [NB];
  logic [CW-1:0] ras   [NB];
  logic [CW-1:0] rrd;

  st_t        eff    [NB];
  logic       eff_ap [NB];
  logic       fresh  [NB];
  logic [3:0] berr   [NB];
  logic       any_mrs, any_ref;
  logic [3:0]      code;
  logic [BA_W-1:0] bank;
  logic            legal;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      eff[b] = st[b];
      eff_ap[b] = ap[b];
      fresh[b] = 1'b0;
      if (cnt[b] == '0) begin
        case (st[b])
          S_ACTG: eff[b] = S_ACT;
          S_PRE, S_REF, S_MRS: eff[b] = S_IDLE;
          S_RD: if (ap[b]) begin eff[b] = S_PRE; fresh[b] = 1'b1; end
                else eff[b] = S_ACT;
          S_WR: begin eff[b] = S_WREC; fresh[b] = 1'b1; end
          S_WREC: if (ap[b]) begin eff[b] = S_PRE; fresh[b] = 1'b1; end
                  else eff[b] = S_ACT;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    any_mrs = 1'b0;
    any_ref = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (eff[b] == S_MRS) any_mrs = 1'b1;
      if (eff[b] == S_REF) any_ref = 1'b1;
      berr[b] = E_NONE;
      if (eff_ap[b] && (eff[b] == S_RD || eff[b] == S_WR || eff[b] == S_WREC)) begin
        if (c_act | c_rd | c_wr | c_pre) berr[b] = E_AUTO;
      end else begin
        case (eff[b])
          S_IDLE: if (c_rd | c_wr) berr[b] = E_NOROW;
          S_ACTG: begin
            if (c_act) berr[b] = E_OPEN;
            else if (c_rd | c_wr) berr[b] = E_RCD;
            else if (c_pre && ras[b] != '0) berr[b] = E_RAS;
          end
          S_ACT, S_RD, S_WR: begin
            if (c_act) berr[b] = E_OPEN;
            else if (c_pre && ras[b] != '0) berr[b] = E_RAS;
          end
          S_WREC: begin
            if (c_act) berr[b] = E_OPEN;
            else if (c_pre) berr[b] = E_WREC;
          end
          S_PRE: if (c_act | c_rd | c_wr) berr[b] = E_PRE;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    code = E_NONE;
    bank = ba;
    if (!c_nop) begin
      if (any_mrs) code = E_MRD;
      else if (any_ref) code = E_RFC;
      else if (c_mrs | c_ref) begin
        for (int b = NB - 1; b >= 0; b--)
          if (eff[b] != S_IDLE) begin code = E_BUSY; bank = BA_W'(b); end
      end else if (c_pre & a10) begin
        for (int b = NB - 1; b >= 0; b--)
          if (berr[b] != E_NONE) begin code = berr[b]; bank = BA_W'(b); end
      end else begin
        code = berr[ba];
        if (code == E_NONE && c_act && rrd != '0) code = E_RRD;
      end
    end
  end

  assign legal = (code == E_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_code  <= E_NONE;
      err_bank  <= '0;
      rrd       <= '0;
      for (int b = 0; b < NB; b++) begin
        st[b]  <= S_IDLE;
        cnt[b] <= '0;
        ap[b]  <= 1'b0;
        ras[b] <= '0;
      end
    end else begin
      err_pulse <= !legal;
      err_code  <= code;
      err_bank  <= bank;
      if (legal && c_act) rrd <= CW'(T_RRD - 1);
      else if (rrd != '0) rrd <= rrd - 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (legal && c_act && ba == BA_W'(b)) ras[b] <= CW'(T_RAS - 1);
        else if (ras[b] != '0) ras[b] <= ras[b] - 1'b1;

        st[b] <= eff[b];
        ap[b] <= eff_ap[b];
        if (fresh[b]) cnt[b] <= (eff[b] == S_WREC) ? CW'(T_WR - 1) : CW'(T_RP - 1);
        else if (cnt[b] != '0) cnt[b] <= cnt[b] - 1'b1;

        if (legal) begin
          if (c_mrs) begin
            st[b] <= S_MRS; cnt[b] <= CW'(T_MRD - 1);
          end else if (c_ref) begin
            st[b] <= S_REF; cnt[b] <= CW'(T_RC - 1);
          end else if (c_act && ba == BA_W'(b)) begin
            st[b] <= S_ACTG; cnt[b] <= CW'(T_RCD - 1); ap[b] <= 1'b0;
          end else if ((c_rd | c_wr) && ba == BA_W'(b)) begin
            st[b] <= c_rd ? S_RD : S_WR; cnt[b] <= CW'(BURST - 1); ap[b] <= a10;
          end else if (c_pre && (a10 || ba == BA_W'(b)) &&
                       (eff[b] == S_ACTG || eff[b] == S_ACT || eff[b] == S_RD || eff[b] == S_WR)) begin
            st[b] <= S_PRE; cnt[b] <= CW'(T_RP - 1); ap[b] <= 1'b0;
          end else if (c_bst && !eff_ap[b] && (eff[b] == S_RD || eff[b] == S_WR)) begin
            st[b]  <= (eff[b] == S_RD) ? S_ACT : S_WREC;
            cnt[b] <= (eff[b] == S_RD) ? '0 : CW'(T_WR - 1);
          end
        end
      end
    end
  end
endmodule

module sdram_bank_checker_props #(
  parameter int T_RRD = 2,
  parameter int T_MRD = 2,
  parameter int T_RC  = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       err_pulse,
  input logic [3:0] err_code
);
  logic nop, act, mrs, rfr;
  assign nop = cs_n | (ras_n & cas_n & we_n);
  assign act = ~cs_n & ~ras_n &  cas_n &  we_n;
  assign mrs = ~cs_n & ~ras_n & ~cas_n & ~we_n;
  assign rfr = ~cs_n & ~ras_n & ~cas_n &  we_n;

  p_quiet_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nop |=> !err_pulse);

  p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_code != 4'd0 && err_code <= 4'd11));

  p_act_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD > 1 && act && $past(act) && !err_pulse) |=> err_pulse);

  p_mode_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (T_MRD > 1 && !nop && $past(mrs) && !err_pulse) |=> err_pulse);

  p_refresh_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RC > 1 && !nop && $past(rfr) && !err_pulse) |=> err_pulse);
endmodule

bind sdram_bank_checker sdram_bank_checker_props #(
  .T_RRD(T_RRD), .T_MRD(T_MRD), .T_RC(T_RC)
) u_props (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/tb_sdram_bank_checker.sv
`timescale 1ns/1ps
module tb_sdram_bank_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic a10 = 1'b0;
  logic err_pulse;
  logic [3:0] err_code;
  logic [1:0] err_bank;

  localparam logic [3:0] MRS = 4'b0000, REF = 4'b0001, PRE = 4'b0010, ACT = 4'b0011,
                         WR = 4'b0100, RD = 4'b0101, NOP = 4'b0111, DES = 4'b1000;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] code_q[$];
  logic [1:0] bank_q[$];
  string      tag_q[$];

  sdram_bank_checker dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10),
    .err_pulse(err_pulse), .err_code(err_code), .err_bank(err_bank)
  );

  always #2.5 clk = ~clk;

  task automatic issue(input logic [3:0] op, input logic [1:0] b, input logic a,
                       input logic [3:0] ec, input logic [1:0] eb, input string tag);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = op;
    ba = b;
    a10 = a;
    code_q.push_back(ec);
    bank_q.push_back(eb);
    tag_q.push_back(tag);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(NOP, 2'd0, 1'b0, 4'd0, 2'd0, "R1");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (code_q.size() > 0) begin
        logic [3:0] ec;
        logic [1:0] eb;
        string tg;
        ec = code_q.pop_front();
        eb = bank_q.pop_front();
        tg = tag_q.pop_front();
        total++;
        if (err_pulse !== (ec != 4'd0) || (ec != 4'd0 && (err_code !== ec || err_bank !== eb))) begin
          bad++;
          $display("FAIL %s: pulse=%0b code=%0d bank=%0d expected pulse=%0b code=%0d bank=%0d",
                   tg, err_pulse, err_code, err_bank, ec != 4'd0, ec, eb);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (err_pulse !== 1'b0 || err_code !== 4'd0) begin
      bad++;
      $display("FAIL R1 reset: pulse=%0b code=%0d expected pulse=0 code=0", err_pulse, err_code);
    end
    rst_n = 1'b1;

    issue(RD,  2'd0, 1'b0, 4'd2,  2'd0, "R3 read to idle bank");
    issue(ACT, 2'd0, 1'b0, 4'd0,  2'd0, "R1 legal activate");
    issue(ACT, 2'd1, 1'b0, 4'd7,  2'd1, "R8 activate spacing");
    issue(RD,  2'd0, 1'b0, 4'd4,  2'd0, "R5 read before tRCD");
    issue(PRE, 2'd0, 1'b0, 4'd10, 2'd0, "R11 precharge before tRAS");
    issue(RD,  2'd0, 1'b0, 4'd0,  2'd0, "R5 read at tRCD");
    issue(ACT, 2'd0, 1'b0, 4'd3,  2'd0, "R4 activate open row");
    issue(ACT, 2'd1, 1'b0, 4'd0,  2'd1, "R13 other bank activate");
    nops(1);
    issue(PRE, 2'd0, 1'b0, 4'd0,  2'd0, "R11 precharge after tRAS");
    issue(ACT, 2'd0, 1'b0, 4'd5,  2'd0, "R6 activate while precharging");
    issue(MRS, 2'd0, 1'b0, 4'd1,  2'd0, "R2 mode set not all idle");
    issue(WR,  2'd1, 1'b1, 4'd0,  2'd1, "R7 write with auto-precharge");
    issue(PRE, 2'd1, 1'b0, 4'd6,  2'd1, "R7 precharge during auto burst");
    issue(RD,  2'd1, 1'b0, 4'd6,  2'd1, "R7 read during auto burst");
    nops(1);
    issue(ACT, 2'd1, 1'b0, 4'd6,  2'd1, "R7 activate during auto recovery");
    issue(RD,  2'd0, 1'b0, 4'd2,  2'd0, "R13 own state of idle bank");
    issue(RD,  2'd1, 1'b0, 4'd5,  2'd1, "R6 read during auto precharge");
    issue(REF, 2'd0, 1'b0, 4'd1,  2'd1, "R2 refresh not all idle");
    nops(1);
    issue(REF, 2'd0, 1'b0, 4'd0,  2'd0, "R6 idle after tRP then refresh");
    issue(ACT, 2'd2, 1'b0, 4'd9,  2'd2, "R10 activate during refresh");
    issue(DES, 2'd0, 1'b0, 4'd0,  2'd0, "R1 deselect during refresh");
    nops(4);
    issue(PRE, 2'd3, 1'b0, 4'd9,  2'd3, "R10 precharge during refresh");
    issue(ACT, 2'd2, 1'b0, 4'd0,  2'd2, "R10 activate at tRC");
    issue(PRE, 2'd0, 1'b1, 4'd10, 2'd2, "R13 all-bank precharge scan");
    issue(ACT, 2'd3, 1'b0, 4'd0,  2'd3, "R8 activate at tRRD");
    issue(PRE, 2'd1, 1'b1, 4'd10, 2'd2, "R13 lowest violating bank");
    nops(4);
    issue(PRE, 2'd0, 1'b1, 4'd0,  2'd0, "R13 all-bank precharge legal");
    issue(MRS, 2'd0, 1'b0, 4'd1,  2'd2, "R2 lowest busy bank");
    nops(1);
    issue(MRS, 2'd0, 1'b0, 4'd0,  2'd0, "R2 mode set all idle");
    issue(ACT, 2'd0, 1'b0, 4'd8,  2'd0, "R9 activate in mode window");
    issue(ACT, 2'd3, 1'b0, 4'd0,  2'd3, "R9 activate after mode window");
    nops(2);
    issue(WR,  2'd3, 1'b0, 4'd0,  2'd3, "R12 plain write");
    nops(3);
    issue(PRE, 2'd3, 1'b0, 4'd11, 2'd3, "R12 precharge in write recovery");
    issue(PRE, 2'd3, 1'b0, 4'd11, 2'd3, "R12 precharge late recovery");
    issue(PRE, 2'd3, 1'b0, 4'd0,  2'd3, "R12 precharge after recovery");
    issue(RD,  2'd3, 1'b0, 4'd5,  2'd3, "R6 read while precharging");
    nops(1);
    issue(ACT, 2'd3, 1'b0, 4'd0,  2'd3, "R6 activate after tRP");
    nops(2);
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule